// File: doc/BRIEF.md
# Serial Control Register Write Port

This block is the control-side write port of a small register file. A host drives three wires: an active-low chip select, a serial clock and a serial data line. While chip select is low, the block shifts in one 16-bit command frame, most significant bit first, on each rising serial clock edge. When chip select returns high, the frame is checked and, if it is well formed, its data byte lands in the addressed register. The register contents drive the block's outputs directly.

A frame is accepted only when three things hold: exactly sixteen bits arrived, the two leading identity bits match the fixed device identity, and the direction bit says "write". A frame that fails any of these is dropped with no trace. The three serial wires are asynchronous to the block clock and are brought into its domain through synchronizer chains before any edge is detected.

The outputs are a timing-run control bit (1 = normal operation, 0 = hold internal timing in reset), a 3-bit clock-mode selection and a zero-flag combine mode (0 = each channel flags on its own, 1 = both channels must be zero).

Top module: `s3w_ctrl_port`

## Requirements
- R1: After `rst`, `run_o` is 1, `clk_mode_o` is 0 and `zero_and_o` is 0.
- R2: A frame is the bits sampled on rising `sclk_i` edges while `csn_i` is low, first bit as bit 15; bits [15:14] are the identity, bit [13] the direction, bits [12:8] the register address, bits [7:0] the data. A write takes effect on the outputs four `clk` cycles after `csn_i` rises (with the default two synchronizer stages).
- R3: A frame whose identity bits are not binary 01 changes no output.
- R4: A frame whose direction bit is 0 changes no output.
- R5: A frame with fewer or more than 16 sampled bits changes no output.
- R6: Raising `csn_i` part-way through a frame discards it; the next frame is counted from its own first bit.
- R7: Address 0 loads data bit 0 into `run_o` and data bits [3:1] into `clk_mode_o`; data bits [7:4] are unused. Writing `run_o` to 0 leaves the address 1 contents unchanged.
- R8: Address 1 loads data bit 0 into `zero_and_o`; the other data bits are unused.
- R9: A well-formed frame to any address other than 0 or 1 changes no output.
- R10: Rising `sclk_i` edges while `csn_i` is high are not sampled and do not count towards a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset, loads register defaults |
| csn_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, sampled on rising `sclk_i` |
| run_o | output | 1 | Timing-run control, 1 = normal |
| clk_mode_o | output | 3 | Clock-mode selection |
| zero_and_o | output | 1 | Zero-flag combine mode, 1 = channels ANDed |

## Verification
The assertions take for granted that the serial wires move slowly against `clk`: each level of `sclk_i`, and the setup of `sdi_i` before a rising `sclk_i`, lasts several block cycles, so that the synchronized copies of data and clock never disagree about which bit is sampled. The stimulus holds every serial level for four block cycles, changes `sdi_i` only while `sclk_i` is low, and leaves at least a dozen idle cycles between frames, so only one commit is ever in flight. Within that envelope the frames cover good writes to both registers, wrong identity, wrong direction, short, long, aborted and unmapped-address frames, and clock edges with chip select high.

// File: rtl/s3w_pkg.sv
package s3w_pkg;

    localparam int ID_W   = 2;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam logic [ID_W-1:0] DEVICE_ID = 2'b01;
    localparam logic            DIR_WRITE = 1'b1;

    typedef struct packed {
        logic [ID_W-1:0]   chip;
        logic              dir;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam int FRAME_BITS = $bits(frame_t);

    typedef enum logic [ADDR_W-1:0] {
        REG_TIMING = 5'd0,
        REG_ZDET   = 5'd1
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] clk_mode;
        logic       run;
    } timing_reg_t;

    typedef struct packed {
        logic zero_and;
    } zdet_reg_t;

    localparam timing_reg_t TIMING_DEFAULT = '{clk_mode: 3'd0, run: 1'b1};
    localparam zdet_reg_t   ZDET_DEFAULT   = '{zero_and: 1'b0};

    function automatic logic frame_ok(input frame_t f);
        return (f.chip == DEVICE_ID) && (f.dir == DIR_WRITE);
    endfunction

    function automatic timing_reg_t to_timing(input logic [DATA_W-1:0] d);
        timing_reg_t t;
        t.run      = d[0];
        t.clk_mode = d[3:1];
        return t;
    endfunction

    function automatic zdet_reg_t to_zdet(input logic [DATA_W-1:0] d);
        zdet_reg_t z;
        z.zero_and = d[0];
        return z;
    endfunction

endpackage

// File: rtl/s3w_sync.sv
module s3w_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RESET_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/s3w_shifter.sv
module s3w_shifter
    import s3w_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   csn_s,
    input  logic   sclk_s,
    input  logic   sdi_s,
    output frame_t frame_o,
    output logic   frame_vld_o
);
    localparam int CNT_MAX = FRAME_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic                  csn_q;
    logic                  sclk_q;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      cnt;
    logic                  sclk_rise;
    logic                  csn_rise;

    assign sclk_rise = sclk_s && !sclk_q && !csn_s;
    assign csn_rise  = csn_s && !csn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q       <= 1'b1;
            sclk_q      <= 1'b0;
            shreg       <= '0;
            cnt         <= '0;
            frame_vld_o <= 1'b0;
        end else begin
            csn_q       <= csn_s;
            sclk_q      <= sclk_s;
            frame_vld_o <= csn_rise && (cnt == CNT_W'(FRAME_BITS));
            if (csn_s) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_o = frame_t'(shreg);

    // R5: the bit counter never passes its saturation value
    p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CNT_MAX));

    // R6: with select high the count is empty on the next cycle
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (cnt == '0));

    // R10: no data shifts in while select is high
    p_no_shift_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (csn_s && csn_q) |=> $stable(shreg));

    // R2: a commit request lasts one cycle
    p_vld_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |=> !frame_vld_o);
endmodule

// File: rtl/s3w_regfile.sv
module s3w_regfile
    import s3w_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_vld_i,
    input  frame_t      frame_i,
    output timing_reg_t timing_o,
    output zdet_reg_t   zdet_o
);
    timing_reg_t timing_q;
    zdet_reg_t   zdet_q;
    logic        accept;
    logic        wr_timing;
    logic        wr_zdet;

    assign accept    = frame_vld_i && frame_ok(frame_i);
    assign wr_timing = accept && (frame_i.addr == REG_TIMING);
    assign wr_zdet   = accept && (frame_i.addr == REG_ZDET);

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= TIMING_DEFAULT;
            zdet_q   <= ZDET_DEFAULT;
        end else begin
            if (wr_timing) timing_q <= to_timing(frame_i.data);
            if (wr_zdet)   zdet_q   <= to_zdet(frame_i.data);
        end
    end

    assign timing_o = timing_q;
    assign zdet_o   = zdet_q;

    // R3: wrong identity leaves both registers alone
    p_bad_id_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && frame_i.chip != DEVICE_ID) |=> ($stable(timing_q) && $stable(zdet_q)));

    // R4: read direction leaves both registers alone
    p_bad_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && frame_i.dir != DIR_WRITE) |=> ($stable(timing_q) && $stable(zdet_q)));

    // R5: without a commit request nothing changes
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !frame_vld_i |=> ($stable(timing_q) && $stable(zdet_q)));

    // R7: a timing write leaves the zero-mode register unchanged
    p_timing_only_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && frame_i.addr == REG_TIMING) |=> $stable(zdet_q));

    // R9: unmapped addresses write nothing
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && frame_i.addr != REG_TIMING && frame_i.addr != REG_ZDET)
        |=> ($stable(timing_q) && $stable(zdet_q)));
endmodule

// File: rtl/s3w_ctrl_port.sv
module s3w_ctrl_port
    import s3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       csn_i,
    input  logic       sclk_i,
    input  logic       sdi_i,
    output logic       run_o,
    output logic [2:0] clk_mode_o,
    output logic       zero_and_o
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] IDLE = 3'b100;

    logic [NSIG-1:0] pins_s;
    frame_t          frame;
    logic            frame_vld;
    timing_reg_t     timing;
    zdet_reg_t       zdet;

    s3w_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({csn_i, sclk_i, sdi_i}),
        .dout (pins_s)
    );

    s3w_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .csn_s       (pins_s[2]),
        .sclk_s      (pins_s[1]),
        .sdi_s       (pins_s[0]),
        .frame_o     (frame),
        .frame_vld_o (frame_vld)
    );

    s3w_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .frame_vld_i (frame_vld),
        .frame_i     (frame),
        .timing_o    (timing),
        .zdet_o      (zdet)
    );

    assign run_o      = timing.run;
    assign clk_mode_o = timing.clk_mode;
    assign zero_and_o = zdet.zero_and;

    // R1: defaults one cycle after reset
    p_reset_vals_r1: assert property (@(posedge clk)
        $past(rst) |-> (run_o && clk_mode_o == 3'd0 && !zero_and_o));
endmodule

// File: tb/s3w_ctrl_port_tb.sv
module s3w_ctrl_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csn_i = 1'b1;
    logic       sclk_i = 1'b0;
    logic       sdi_i = 1'b0;
    logic       run_o;
    logic [2:0] clk_mode_o;
    logic       zero_and_o;

    always #2.5 clk = ~clk;

    s3w_ctrl_port u_dut (
        .clk(clk), .rst(rst), .csn_i(csn_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .run_o(run_o), .clk_mode_o(clk_mode_o), .zero_and_o(zero_and_o)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural model
    logic       exp_run = 1'b1;
    logic [2:0] exp_mode = 3'd0;
    logic       exp_zand = 1'b0;
    logic [15:0] m_shift = '0;
    int          m_cnt = 0;
    bit          pend = 0;
    int          pend_at = 0;
    logic [15:0] pend_word = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (pend && cyc >= pend_at) begin
            pend = 0;
            if (pend_word[15:14] == 2'b01 && pend_word[13] == 1'b1) begin
                if (pend_word[12:8] == 5'd0) begin
                    exp_run  = pend_word[0];
                    exp_mode = pend_word[3:1];
                end else if (pend_word[12:8] == 5'd1) begin
                    exp_zand = pend_word[0];
                end
            end
        end
        if (cmp_en && !done) begin
            vectors++;
            if (run_o !== exp_run || clk_mode_o !== exp_mode || zero_and_o !== exp_zand) begin
                miscompares++;
                $display("FAIL %s cyc %0d: actual run=%b mode=%0d zand=%b expected run=%b mode=%0d zand=%b",
                         cur_req, cyc, run_o, clk_mode_o, zero_and_o, exp_run, exp_mode, exp_zand);
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse(input logic b);
        sdi_i = b;
        hold(4);
        sclk_i = 1'b1;
        if (!csn_i) begin
            m_shift = {m_shift[14:0], b};
            m_cnt++;
        end
        hold(4);
        sclk_i = 1'b0;
    endtask

    task automatic cs_low();
        csn_i = 1'b0;
        m_cnt = 0;
        hold(4);
    endtask

    task automatic cs_high();
        hold(4);
        csn_i = 1'b1;
        if (m_cnt == 16) begin
            pend      = 1;
            pend_at   = cyc + 4;
            pend_word = m_shift;
        end
        m_cnt = 0;
        hold(16);
    endtask

    // send the low n bits of w, most significant first
    task automatic send(input logic [31:0] w, input int n);
        cs_low();
        for (int i = n - 1; i >= 0; i--) sclk_pulse(w[i]);
        cs_high();
    endtask

    function automatic logic [15:0] mk(input logic [1:0] id, input logic dir,
                                       input logic [4:0] a, input logic [7:0] d);
        return {id, dir, a, d};
    endfunction

    initial begin
        hold(3);
        rst = 1'b0;
        cmp_en = 1;
        cur_req = "R1";
        hold(8);

        cur_req = "R7";  // addr 0: bit0 run, bits3:1 mode
        send(32'(mk(2'b01, 1'b1, 5'd0, 8'hF6)), 16);   // run=0 mode=3
        cur_req = "R8";
        send(32'(mk(2'b01, 1'b1, 5'd1, 8'hFF)), 16);   // zand=1
        cur_req = "R7";  // clear run again, zero mode must stay
        send(32'(mk(2'b01, 1'b1, 5'd0, 8'h0A)), 16);
        cur_req = "R2";
        send(32'(mk(2'b01, 1'b1, 5'd0, 8'h0F)), 16);   // run=1 mode=7

        cur_req = "R3";
        send(32'(mk(2'b10, 1'b1, 5'd0, 8'h00)), 16);
        send(32'(mk(2'b00, 1'b1, 5'd1, 8'h00)), 16);
        send(32'(mk(2'b11, 1'b1, 5'd0, 8'h02)), 16);
        cur_req = "R4";
        send(32'(mk(2'b01, 1'b0, 5'd0, 8'h00)), 16);
        send(32'(mk(2'b01, 1'b0, 5'd1, 8'h00)), 16);
        cur_req = "R5";
        send(32'(mk(2'b01, 1'b1, 5'd0, 8'h00)) >> 1, 15);
        send({16'h0, mk(2'b01, 1'b1, 5'd1, 8'h00)}, 17);
        send({mk(2'b01, 1'b1, 5'd0, 8'h00), 16'h0}, 32);
        cur_req = "R6";
        send(32'h0000_0005, 5);                          // aborted
        send(32'(mk(2'b01, 1'b1, 5'd1, 8'h00)), 16);     // fresh count, zand=0
        cur_req = "R9";
        send(32'(mk(2'b01, 1'b1, 5'd2, 8'h00)), 16);
        send(32'(mk(2'b01, 1'b1, 5'd31, 8'h00)), 16);

        cur_req = "R10";  // edges with select high, then a good frame
        for (int i = 0; i < 6; i++) sclk_pulse(1'b1);
        send(32'(mk(2'b01, 1'b1, 5'd0, 8'h04)), 16);     // run=0 mode=2
        cur_req = "R2";
        send(32'(mk(2'b01, 1'b1, 5'd1, 8'h01)), 16);

        cur_req = "R1";
        rst = 1'b1;
        exp_run = 1'b1; exp_mode = 3'd0; exp_zand = 1'b0;
        cmp_en = 0;
        hold(2);
        rst = 1'b0;
        cmp_en = 1;
        hold(10);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule